// File: doc/BRIEF.md
# Fixed Off-Time Bridge Current Chopper

This block regulates the winding current of one full bridge. It turns on a diagonal pair of switches. When a synchronized current-sense comparator reports that the winding current has reached its threshold, the block removes drive for a fixed number of clock cycles and then drives again. During that off-time the current recirculates in one of two ways. In slow decay both low-side switches conduct. In mixed decay the opposite diagonal conducts first, which is fast decay, and the bridge then falls back to slow decay.

The comparator is not trusted right after the bridge starts driving. Switching transients would produce false trips, so a blanking window masks it. A zero-current detect input stops synchronous rectification for the rest of the off-time, so the load current cannot reverse. Each leg passes through a one-cycle all-off state whenever it moves between its high and low switch.

Top module: `offtime_chopper`

## Requirements
- R1: While reset is held and on the first cycle after it, gate_o is 0. The bit positions are gate_o[0] A-high, gate_o[1] A-low, gate_o[2] B-high and gate_o[3] B-low.
- R2: During drive, pol_i=0 selects A-high with B-low (4'b1001), and pol_i=1 selects B-high with A-low (4'b0110). The drive pair follows pol_i, and drive resumes after every off-time.
- R3: In slow decay (mode latched as 0 at the trip), both low-side switches are on during the off-time (4'b1010).
- R4: In mixed decay (mode latched as 1 at the trip), the first (T>>4)*5 cycles of the off-time turn on the diagonal opposite the drive pair. The rest of the off-time uses the slow-decay pattern.
- R5: trip_i passes a two-stage synchronizer. It is ignored for BLANK cycles after each start of drive, so a permanently asserted trip gives drive runs of exactly BLANK output cycles.
- R6: If zcd_i is high during the off-time, gate_o is 0 from the next cycle until the off-time ends.
- R7: The high and low switches of one leg are never on together. A leg that moves between them spends one cycle with both off.
- R8: With en_i low, gate_o is 0 on the next cycle and the block goes idle. After en_i rises again, drive appears on the second cycle, and blanking restarts.
- R9: The off-time lasts T cycles, with T = toff_i latched at the trip, or DEF_TOFF (3000, which is 30 us at 100 MHz) when toff_i is 0. Each chop therefore shows T+1 non-drive output cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| en_i | input | 1 | Bridge enable |
| trip_i | input | 1 | Current comparator output, asynchronous |
| mixed_i | input | 1 | Decay select: 1 mixed, 0 slow |
| pol_i | input | 1 | Current polarity of the winding |
| zcd_i | input | 1 | Zero-current detect |
| toff_i | input | TOFF_W | Off-time in cycles, 0 selects the default |
| gate_o | output | 4 | Gate controls {B-low, B-high, A-low, A-high} |

## Verification
The hardest situation to reach is the fast-to-slow hand-over inside a mixed off-time. It has to coincide with the exact split point and with the leg gap it causes. Reaching it needs a trip that survives blanking, and an off-time long enough for the fast portion to be visible. The stimulus holds the comparator permanently tripped, so the bridge chops continuously under chosen off-times (32, 64 and the default). It then counts drive, non-drive and fast-pattern cycles at the pins. A zero-current pulse is timed from the first observed slow-decay cycle.

// File: rtl/offtime_chopper.sv
module offtime_chopper #(
  parameter int TOFF_W   = 16,
  parameter int DEF_TOFF = 3000,
  parameter int BLANK    = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              trip_i,
  input  logic              mixed_i,
  input  logic              pol_i,
  input  logic              zcd_i,
  input  logic [TOFF_W-1:0] toff_i,
  output logic [3:0]        gate_o
);

  localparam int BW = $clog2(BLANK + 1);
  localparam logic [3:0] AH = 4'b0001, AL = 4'b0010, BH = 4'b0100, BL = 4'b1000;

  typedef enum logic [1:0] {S_IDLE, S_DRIVE, S_OFF} st_t;

  st_t               st;
  logic [1:0]        sync;
  logic [TOFF_W-1:0] cnt, tlen, fast_len, teff;
  logic [BW-1:0]     bcnt;
  logic              mix_q, zl, off_ph, fast;
  logic [3:0]        want, nxt;

  assign teff     = (toff_i == '0) ? TOFF_W'(DEF_TOFF) : toff_i;
  assign fast_len = (tlen >> 4) * TOFF_W'(5);
  assign off_ph   = (st == S_OFF);
  assign fast     = mix_q && (cnt < fast_len);

  always_comb begin
    want = 4'b0;
    if (st == S_DRIVE)
      want = pol_i ? (BH | AL) : (AH | BL);
    else if (st == S_OFF) begin
      if (zl || zcd_i)  want = 4'b0;
      else if (fast)    want = pol_i ? (AH | BL) : (BH | AL);
      else              want = AL | BL;
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_leg
    assign nxt[2*k +: 2] = (gate_o[2*k +: 2] != 2'b00 && want[2*k +: 2] != 2'b00 &&
                            want[2*k +: 2] != gate_o[2*k +: 2]) ? 2'b00 : want[2*k +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sync   <= 2'b0;
      cnt    <= '0;
      tlen   <= '0;
      bcnt   <= '0;
      mix_q  <= 1'b0;
      zl     <= 1'b0;
      gate_o <= 4'b0;
    end else begin
      sync <= {sync[0], trip_i};
      if (!en_i) begin
        st     <= S_IDLE;
        zl     <= 1'b0;
        gate_o <= 4'b0;
      end else begin
        gate_o <= nxt;
        case (st)
          S_IDLE: begin
            st   <= S_DRIVE;
            bcnt <= BW'(BLANK);
          end
          S_DRIVE: begin
            if (bcnt != '0) bcnt <= bcnt - BW'(1);
            else if (sync[1]) begin
              st    <= S_OFF;
              cnt   <= '0;
              tlen  <= teff;
              mix_q <= mixed_i;
              zl    <= 1'b0;
            end
          end
          S_OFF: begin
            if (zcd_i) zl <= 1'b1;
            if (cnt == tlen - TOFF_W'(1)) begin
              st   <= S_DRIVE;
              bcnt <= BW'(BLANK);
              zl   <= 1'b0;
            end else
              cnt <= cnt + TOFF_W'(1);
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/offtime_chopper_chk.sv
module offtime_chopper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       zcd_i,
  input logic       off_ph,
  input logic [3:0] gate_o
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> gate_o == 4'b0);

  assert_zero_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && off_ph && zcd_i) |=> gate_o == 4'b0);

  assert_leg_a_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[0] && gate_o[1]));

  assert_leg_a_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_o[0]) |-> !$past(gate_o[1])) and ($rose(gate_o[1]) |-> !$past(gate_o[0])));

  assert_leg_b_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_o[2]) |-> !$past(gate_o[3])) and ($rose(gate_o[3]) |-> !$past(gate_o[2])));

  assert_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> gate_o == 4'b0);

endmodule

bind offtime_chopper offtime_chopper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .zcd_i(zcd_i), .off_ph(off_ph), .gate_o(gate_o)
);

// File: tb/test_offtime_chopper.sv
module test_offtime_chopper;
  localparam int BLANK = 100;
  localparam int DEF_T = 3000;

  logic clk = 0, rst_n = 0, en = 0, trip = 0, mixed = 0, pol = 0, zcd = 0;
  logic [15:0] toff = 16'd40;
  logic [3:0]  gate_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0, cmp_on = 0;

  always #5 clk = ~clk;

  offtime_chopper i_offtime_chopper (
    .clk(clk), .rst_n(rst_n), .en_i(en), .trip_i(trip), .mixed_i(mixed),
    .pol_i(pol), .zcd_i(zcd), .toff_i(toff), .gate_o(gate_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_ph = 0, m_bl = 0, m_el = 0, m_len = 1;
  bit m_mix = 0, m_zl = 0, q1 = 0, q2 = 0;
  bit [3:0] m_g = 0;
  string m_tag = "R1";

  function automatic bit [1:0] leg(input bit [1:0] cur, input bit [1:0] w);
    if ((cur == 2'b01 && w == 2'b10) || (cur == 2'b10 && w == 2'b01)) return 2'b00;
    return w;
  endfunction

  always @(posedge clk) begin : model
    bit [3:0] w, nx;
    bit tr, fst;
    if (!rst_n) begin
      m_ph = 0; m_zl = 0; m_g = 0; q1 = 0; q2 = 0; m_tag = "R1";
    end else begin
      tr = q2; q2 = q1; q1 = trip;
      if (!en) begin
        m_ph = 0; m_zl = 0; m_g = 0; m_tag = "R8";
      end else begin
        fst = m_mix && (m_el < (m_len / 16) * 5);
        w = 0;
        if (m_ph == 1) begin w = pol ? 4'b0110 : 4'b1001; m_tag = "R2"; end
        else if (m_ph == 2) begin
          if (m_zl || zcd) begin w = 0; m_tag = "R6"; end
          else if (fst) begin w = pol ? 4'b1001 : 4'b0110; m_tag = "R4"; end
          else begin w = 4'b1010; m_tag = "R3"; end
        end else m_tag = "R8";
        nx = {leg(m_g[3:2], w[3:2]), leg(m_g[1:0], w[1:0])};
        if (nx != w) m_tag = "R7";
        m_g = nx;
        if (m_ph == 0) begin m_ph = 1; m_bl = BLANK; end
        else if (m_ph == 1) begin
          if (m_bl > 0) m_bl--;
          else if (tr) begin
            m_ph = 2; m_el = 0; m_len = (toff == 0) ? DEF_T : toff; m_mix = mixed; m_zl = 0;
          end
        end else begin
          if (zcd) m_zl = 1;
          if (m_el == m_len - 1) begin m_ph = 1; m_bl = BLANK; m_zl = 0; end
          else m_el++;
        end
      end
    end
  end

  always @(negedge clk)
    if (rst_n && cmp_on) chk(gate_o == m_g, m_tag, gate_o, m_g);

  task automatic measure(input bit [3:0] drv, input bit [3:0] fpat,
                         output int dr, output int off, output int fc);
    dr = 0; off = 0; fc = 0;
    while (gate_o != drv) @(negedge clk);
    while (gate_o == drv) begin dr++; @(negedge clk); end
    while (gate_o != drv) begin off++; if (gate_o == fpat) fc++; @(negedge clk); end
  endtask

  task automatic run_case(input bit p, input bit mx, input int t, input string rq);
    int dr, off, fc, tt;
    pol = p; mixed = mx; toff = t[15:0];
    tt = (t == 0) ? DEF_T : t;
    measure(p ? 4'b0110 : 4'b1001, p ? 4'b1001 : 4'b0110, dr, off, fc);
    measure(p ? 4'b0110 : 4'b1001, p ? 4'b1001 : 4'b0110, dr, off, fc);
    chk(dr == BLANK, "R5", dr, BLANK);
    chk(off == tt + 1, "R9", off, tt + 1);
    chk(fc == (mx ? (tt / 16) * 5 - 1 : 0), rq, fc, mx ? (tt / 16) * 5 - 1 : 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    chk(gate_o == 0, "R1", gate_o, 0);
    rst_n = 1;
    @(negedge clk);
    chk(gate_o == 0, "R1", gate_o, 0);
    cmp_on = 1;
    en = 1; trip = 1;
    run_case(0, 0, 40, "R3");
    run_case(0, 1, 32, "R4");
    run_case(1, 1, 64, "R4");
    run_case(0, 1, 0, "R4");
    // zero-current cut
    pol = 0; mixed = 0; toff = 16'd50;
    while (gate_o != 4'b1010) @(negedge clk);
    repeat (5) @(negedge clk);
    zcd = 1;
    @(negedge clk);
    zcd = 0;
    chk(gate_o == 0, "R6", gate_o, 0);
    repeat (3) @(negedge clk);
    chk(gate_o == 0, "R6", gate_o, 0);
    // enable removal and restart
    trip = 0;
    while (gate_o != 4'b1001) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(gate_o == 0, "R8", gate_o, 0);
    repeat (3) @(negedge clk);
    chk(gate_o == 0, "R8", gate_o, 0);
    en = 1;
    @(negedge clk);
    @(negedge clk);
    chk(gate_o == 4'b1001, "R8", gate_o, 9);
    // polarity change in drive
    pol = 1;
    @(negedge clk);
    chk(gate_o == 0, "R7", gate_o, 0);
    @(negedge clk);
    chk(gate_o == 4'b0110, "R2", gate_o, 6);
    repeat (20) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule